// File: doc/BRIEF.md
# Serial Peripheral Byte Controller (Master/Slave)

The block moves one byte at a time over a synchronous serial link in both directions at once. A single shift register sends the stored transmit byte out on the data-out line and gathers the incoming bits from the data-in line, so when the last bit is shifted the register holds the received byte. The block runs either as the clock owner (master), generating the serial clock from the system clock through a prescaler, or as a follower (slave), clocked from the outside while its select input is low.

Software talks to it through three byte registers on a small strobe bus: a control register (enable, role, bit order, clock polarity and phase, rate), a status register (transfer-done and write-collision flags), and a data register (write starts or preloads a transfer, read returns the last received byte). A separate power-down input holds the whole block idle.

Top module: `spi_port`

## Requirements
- R1: A transfer is full duplex: the 8 bits of the written byte leave on `serOut` while 8 bits are gathered from `serIn`, and a read of the data register (address 2) afterwards returns the gathered byte.
- R2: Control bit 5 set selects master role: a write to the data register while idle starts a transfer clocked on `sclkOut`. Bit 5 clear selects slave role: bits are clocked by `sclkIn` edges while `ssN` is low.
- R3: Control bit 6 set sends and receives the least significant bit first; clear sends and receives the most significant bit first.
- R4: In master role the serial clock half period in system cycles is 2, 8, 32, 64 for rate field (control bits 1:0) values 0..3 with control bit 2 (double speed) clear, and 1, 4, 16, 32 with it set, i.e. dividers 4/16/64/128 and 2/8/32/64.
- R5: Control bit 4 is the idle level of the serial clock (`sclkOut` rests at it when no master transfer runs). With control bit 3 clear, data is sampled on the leading clock edge and changed on the trailing edge; with it set, changed on the leading edge and sampled on the trailing edge.
- R6: Status bit 7 (done) becomes set right after the sixteenth serial clock edge of a byte.
- R7: A data-register write while a byte is in flight sets status bit 6 (collision) and leaves the byte being shifted unchanged.
- R8: Both flags clear when a status read (address 1) sees a flag set and a later data-register read or write follows; a data-register access without that prior status read leaves the flags set.
- R9: While `powerDown` is high, control and data writes are ignored, any master transfer stops and `sclkOut` sits at the idle level; reads still work.
- R10: In slave role a high `ssN` returns the bit count to zero, so a byte cut short by deselection never sets the done flag.
- R11: Control bit 7 must be set for the block to generate or follow serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | Holds the block idle and write-protected |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (for read side effects) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| sclkIn | input | 1 | Serial clock from an external master (slave role) |
| ssN | input | 1 | Active-low slave select (slave role) |
| serIn | input | 1 | Serial data in |
| sclkOut | output | 1 | Generated serial clock (master role) |
| serOut | output | 1 | Serial data out |

## Verification
The hardest situation to reach is a byte cut short in slave role: the bench has to play the external master, toggle `sclkIn` slowly enough for the input synchronizers, raise `ssN` after a few edges, and then prove through a full follow-up byte and the status register that no stale bit count survived. Collisions are similarly narrow: the bench issues a second data write at a chosen cycle inside a slow master transfer and checks, from bits it collects off `serOut`, that the original byte still went out. Random rate, order, polarity and phase settings drive both roles against a behavioural link partner whose expected bytes come from bench functions.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Control register bit positions
  localparam int CB_EN   = 7;
  localparam int CB_LSB  = 6;
  localparam int CB_MST  = 5;
  localparam int CB_CPOL = 4;
  localparam int CB_CPHA = 3;
  localparam int CB_DBL  = 2;

  // Status register bit positions
  localparam int SB_DONE = 7;
  localparam int SB_COL  = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // copy transmit byte into shift register
    logic capture;  // latch the incoming bit
    logic shift;    // advance the shift register
    logic finish;   // last edge of the byte
    logic inBit;    // incoming bit for this role
  } dpCtl_t;
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic         lsbFirst,
  input  logic [W-1:0] txByte,
  output logic         serOut,
  output logic [W-1:0] rxByte
);
  logic [W-1:0] shiftReg;
  logic [W-1:0] shiftNext;
  logic         heldBit;
  logic         nextIn;

  // On a combined capture+shift edge the fresh bit goes straight in
  assign nextIn    = ctl.capture ? ctl.inBit : heldBit;
  assign shiftNext = lsbFirst ? {nextIn, shiftReg[W-1:1]}
                              : {shiftReg[W-2:0], nextIn};
  assign serOut    = lsbFirst ? shiftReg[0] : shiftReg[W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      heldBit  <= 1'b0;
      rxByte   <= '0;
    end else begin
      if (ctl.capture) heldBit <= ctl.inBit;
      if (ctl.load)       shiftReg <= txByte;
      else if (ctl.shift) shiftReg <= shiftNext;
      if (ctl.finish)     rxByte   <= shiftNext;
    end
  end
endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl
  import spi_port_pkg::*;
#(
  parameter int W       = 8,
  parameter int SYNC    = 2,
  parameter int DIV_MAX = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerDown,
  input  logic [1:0]   regAddr,
  input  logic         regWr,
  input  logic         regRd,
  input  logic [W-1:0] regWdata,
  input  logic         sclkIn,
  input  logic         ssN,
  input  logic         serIn,
  output dpCtl_t       ctl,
  output logic [W-1:0] ctrlReg,
  output logic [W-1:0] statusReg,
  output logic         xferBusy,
  output logic         sclkOut
);
  localparam int EDGES  = 2 * W;
  localparam int EW     = $clog2(EDGES);
  localparam int HALF_W = $clog2(DIV_MAX / 2) + 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic en, master, cpha, dbl;
  logic [1:0] rate;
  assign en     = ctrlReg[CB_EN];
  assign master = ctrlReg[CB_MST];
  assign cpha   = ctrlReg[CB_CPHA];
  assign dbl    = ctrlReg[CB_DBL];
  assign rate   = ctrlReg[1:0];

  // Input synchronizers for slave role
  logic [SYNC-1:0] sclkSync, serSync, ssSync;
  logic            sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      serSync  <= '0;
      ssSync   <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC-2:0], sclkIn};
      serSync  <= {serSync[SYNC-2:0], serIn};
      ssSync   <= {ssSync[SYNC-2:0], ssN};
      sclkPrev <= sclkSync[SYNC-1];
    end
  end

  // Prescaler half period
  logic [HALF_W-1:0] halfBase, halfLim, halfCnt;
  always_comb begin
    case (rate)
      2'd0:    halfBase = HALF_W'(DIV_MAX / 64);
      2'd1:    halfBase = HALF_W'(DIV_MAX / 16);
      2'd2:    halfBase = HALF_W'(DIV_MAX / 4);
      default: halfBase = HALF_W'(DIV_MAX / 2);
    endcase
    halfLim = dbl ? (halfBase >> 1) : halfBase;
  end

  logic          busy, sclkLvl, armed, doneFlag, colFlag;
  logic [EW-1:0] edgeCnt;
  logic          masterRun, slaveRun, edgeNow, lead, lastEdge;
  logic          dataWr, dataAcc, statRead, accept, collide, clearFlags;

  assign masterRun = en && master && !powerDown;
  assign slaveRun  = en && !master && !powerDown && !ssSync[SYNC-1];
  assign edgeNow   = master ? (masterRun && busy && halfCnt == halfLim - 1'b1)
                            : (slaveRun && sclkSync[SYNC-1] != sclkPrev);
  assign lead      = ~edgeCnt[0];
  assign lastEdge  = edgeCnt == LAST_EDGE;

  assign xferBusy   = master ? busy : (edgeCnt != '0);
  assign dataWr     = regWr && regAddr == ADDR_DATA && !powerDown;
  assign dataAcc    = (regWr || regRd) && regAddr == ADDR_DATA;
  assign statRead   = regRd && regAddr == ADDR_STAT;
  assign accept     = dataWr && !xferBusy;
  assign collide    = dataWr && xferBusy;
  assign clearFlags = dataAcc && armed;

  always_comb begin
    ctl.load    = accept;
    ctl.capture = edgeNow && (cpha ? !lead : lead);
    ctl.shift   = edgeNow && (cpha ? ((lead && edgeCnt != '0) || lastEdge) : !lead);
    ctl.finish  = edgeNow && lastEdge;
    ctl.inBit   = master ? serIn : serSync[SYNC-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      busy     <= 1'b0;
      halfCnt  <= '0;
      sclkLvl  <= 1'b0;
      edgeCnt  <= '0;
      armed    <= 1'b0;
      doneFlag <= 1'b0;
      colFlag  <= 1'b0;
    end else begin
      if (regWr && regAddr == ADDR_CTRL && !powerDown) ctrlReg <= regWdata;

      // Master clock generator
      if (!masterRun) begin
        busy    <= 1'b0;
        halfCnt <= '0;
        sclkLvl <= 1'b0;
      end else if (busy) begin
        if (edgeNow) begin
          halfCnt <= '0;
          sclkLvl <= ~sclkLvl;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
        if (ctl.finish) busy <= 1'b0;
      end else if (accept) begin
        busy    <= 1'b1;
        halfCnt <= '0;
      end

      // Edge counter shared by both roles
      if (master ? !(masterRun && busy) : !slaveRun) edgeCnt <= '0;
      else if (edgeNow) edgeCnt <= lastEdge ? '0 : edgeCnt + 1'b1;

      // Flag clear sequence
      if (statRead && (doneFlag || colFlag)) armed <= 1'b1;
      else if (clearFlags)                   armed <= 1'b0;
      doneFlag <= ctl.finish || (doneFlag && !clearFlags);
      colFlag  <= collide    || (colFlag  && !clearFlags);
    end
  end

  assign sclkOut = ctrlReg[CB_CPOL] ^ sclkLvl;

  always_comb begin
    statusReg          = '0;
    statusReg[SB_DONE] = doneFlag;
    statusReg[SB_COL]  = colFlag;
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int W       = 8,
  parameter int SYNC    = 2,
  parameter int DIV_MAX = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerDown,
  input  logic [1:0]   regAddr,
  input  logic         regWr,
  input  logic         regRd,
  input  logic [W-1:0] regWdata,
  output logic [W-1:0] regRdata,
  input  logic         sclkIn,
  input  logic         ssN,
  input  logic         serIn,
  output logic         sclkOut,
  output logic         serOut
);
  dpCtl_t       dpCtl;
  logic [W-1:0] ctrlReg, statusReg, rxByte;
  logic         xferBusy;

  spi_port_ctl #(.W(W), .SYNC(SYNC), .DIV_MAX(DIV_MAX)) u_ctl (
    .clk(clk), .rstN(rstN), .powerDown(powerDown),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .sclkIn(sclkIn), .ssN(ssN), .serIn(serIn),
    .ctl(dpCtl), .ctrlReg(ctrlReg), .statusReg(statusReg),
    .xferBusy(xferBusy), .sclkOut(sclkOut)
  );

  spi_port_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .lsbFirst(ctrlReg[CB_LSB]),
    .txByte(regWdata), .serOut(serOut), .rxByte(rxByte)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = ctrlReg;
      ADDR_STAT: regRdata = statusReg;
      ADDR_DATA: regRdata = rxByte;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         powerDown,
  input logic [1:0]   regAddr,
  input logic         regWr,
  input logic [W-1:0] ctrlReg,
  input logic [W-1:0] statusReg,
  input logic         xferBusy,
  input logic         finishStb,
  input logic         sclkOut
);
  assert_pd_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> $stable(ctrlReg));

  assert_pd_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> sclkOut == ctrlReg[CB_CPOL]);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[CB_MST] && !xferBusy) |-> sclkOut == ctrlReg[CB_CPOL]);

  assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_DATA && !powerDown && xferBusy) |=> statusReg[SB_COL]);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    finishStb |=> statusReg[SB_DONE]);

  assert_done_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[SB_DONE]) |-> $past(finishStb));
endmodule

bind spi_port spi_port_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .powerDown(powerDown), .regAddr(regAddr),
  .regWr(regWr), .ctrlReg(ctrlReg), .statusReg(statusReg),
  .xferBusy(xferBusy), .finishStb(dpCtl.finish), .sclkOut(sclkOut)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerDown = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       sclkIn = 1'b0;
  logic       ssN = 1'b1;
  logic       serIn = 1'b0;
  logic       sclkOut;
  logic       serOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .sclkIn(sclkIn), .ssN(ssN), .serIn(serIn), .sclkOut(sclkOut), .serOut(serOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkCtrl(input bit en, input bit lsb, input bit mst,
                                        input bit cpol, input bit cpha, input bit dbl,
                                        input logic [1:0] rate);
    return {en, lsb, mst, cpol, cpha, dbl, rate};
  endfunction

  function automatic int halfOf(input logic [1:0] rate, input bit dbl);
    int base;
    case (rate)
      2'd0: base = 2;
      2'd1: base = 8;
      2'd2: base = 32;
      default: base = 64;
    endcase
    return dbl ? base / 2 : base;
  endfunction

  function automatic logic bitOf(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7 - i];
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Reads back data, then status (expecting stsExp), then data again and status 0.
  task automatic finishAndClear(input logic [7:0] rxExp, input logic [7:0] stsExp);
    logic [7:0] v;
    regRead(2'd2, v);
    check(v == rxExp, "R1 received byte", v, rxExp);
    regRead(2'd1, v);
    check(v == stsExp, "R6/R8 flags survive unarmed data read", v, stsExp);
    regRead(2'd2, v);
    regRead(2'd1, v);
    check(v == 8'h00, "R8 flags cleared after status then data", v, 0);
  endtask

  // DUT as master; bench is the link partner.
  task automatic runMaster(input bit lsb, input bit cpol, input bit cpha,
                           input logic [1:0] rate, input bit dbl,
                           input logic [7:0] txB, input logic [7:0] slvB, input int colAt);
    int k = 0, cyc = 0, e0 = 0, e1 = 0;
    logic ps, pso;
    logic [7:0] got = 8'd0;
    bit isLead, samp;
    regWrite(2'd0, mkCtrl(1'b1, lsb, 1'b1, cpol, cpha, dbl, rate));
    check(sclkOut == cpol, "R5 idle clock level", sclkOut, cpol);
    serIn = bitOf(slvB, 0, lsb);
    regWrite(2'd2, txB);
    ps = sclkOut; pso = serOut;
    while (k < 16 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (colAt != 0 && cyc == colAt) begin
        regAddr = 2'd2; regWdata = ~txB; regWr = 1'b1;
      end else if (colAt != 0 && cyc == colAt + 1) begin
        regWr = 1'b0;
      end
      if (sclkOut != ps) begin
        isLead = (k % 2) == 0;
        samp   = cpha ? !isLead : isLead;
        if (samp) got = lsb ? {pso, got[7:1]} : {got[6:0], pso};
        if (k == 0) e0 = cyc;
        if (k == 1) e1 = cyc;
        if (!cpha && !isLead && k < 15) serIn = bitOf(slvB, (k + 1) / 2, lsb);
        if (cpha && isLead) serIn = bitOf(slvB, k / 2, lsb);
        k++;
      end
      ps = sclkOut; pso = serOut;
    end
    regWr = 1'b0;
    check(k == 16, "R2 master produced 16 clock edges", k, 16);
    check(e1 - e0 == halfOf(rate, dbl), "R4 half period", e1 - e0, halfOf(rate, dbl));
    check(got == txB, "R3/R7 serial byte sent", got, txB);
    idle(2);
    check(sclkOut == cpol, "R5 clock back at idle", sclkOut, cpol);
    finishAndClear(slvB, colAt != 0 ? 8'hC0 : 8'h80);
  endtask

  // DUT as slave; bench is the clock owner.
  task automatic runSlave(input bit lsb, input bit cpol, input bit cpha,
                          input logic [7:0] txB, input logic [7:0] mstB, input int abortEdges);
    logic [7:0] got = 8'd0;
    logic [7:0] v;
    bit isLead;
    regWrite(2'd0, mkCtrl(1'b1, lsb, 1'b0, cpol, cpha, 1'b0, 2'd0));
    sclkIn = cpol; ssN = 1'b1;
    idle(4);
    regWrite(2'd2, txB);
    if (abortEdges > 0) begin
      ssN = 1'b0;
      idle(4);
      for (int k = 0; k < abortEdges; k++) begin
        sclkIn = ~sclkIn;
        idle(4);
      end
      ssN = 1'b1;
      idle(6);
      sclkIn = cpol;
      idle(4);
      regRead(2'd1, v);
      check(v == 8'h00, "R10 cut-short byte sets no flag", v, 0);
      regWrite(2'd2, txB);
    end
    serIn = bitOf(mstB, 0, lsb);
    ssN = 1'b0;
    idle(4);
    for (int k = 0; k < 16; k++) begin
      isLead = (k % 2) == 0;
      if (cpha ? !isLead : isLead) got = lsb ? {serOut, got[7:1]} : {got[6:0], serOut};
      sclkIn = ~sclkIn;
      if (cpha && isLead) serIn = bitOf(mstB, k / 2, lsb);
      if (!cpha && !isLead && k < 15) serIn = bitOf(mstB, (k + 1) / 2, lsb);
      idle(4);
    end
    idle(4);
    ssN = 1'b1;
    check(got == txB, "R2/R3 slave byte sent", got, txB);
    finishAndClear(mstB, 8'h80);
  endtask

  initial begin
    logic [7:0] v;
    int edges;
    logic last;
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // Reset state
    regRead(2'd0, v); check(v == 8'h00, "R11 control after reset", v, 0);
    regRead(2'd1, v); check(v == 8'h00, "R6 status after reset", v, 0);
    regRead(2'd2, v); check(v == 8'h00, "R1 data after reset", v, 0);
    check(sclkOut == 1'b0, "R5 clock after reset", sclkOut, 0);

    // Directed: every rate setting
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 2; d++)
        runMaster(1'b0, 1'b0, 1'b0, 2'(r), d[0], 8'hA5, 8'h3C, 0);

    // Directed: all four clock modes, both orders
    for (int m = 0; m < 8; m++)
      runMaster(m[2], m[1], m[0], 2'd0, 1'b1, 8'h81, 8'h7E, 0);

    // R7: collision mid-transfer at slowest rate
    runMaster(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 8'hC3, 8'h5A, 300);
    runMaster(1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 8'h0F, 8'hF0, 20);

    // R11: disabled block produces no clock
    regWrite(2'd0, mkCtrl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0));
    regWrite(2'd2, 8'h55);
    edges = 0; last = sclkOut;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclkOut != last) edges++;
      last = sclkOut;
    end
    check(edges == 0, "R11 no clock while disabled", edges, 0);
    regRead(2'd1, v); check(v == 8'h00, "R11 no done while disabled", v, 0);

    // R9: power-down ignores writes and halts a running transfer
    regWrite(2'd0, mkCtrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2));
    regWrite(2'd2, 8'h99);
    idle(100);
    powerDown = 1'b1;
    idle(2);
    check(sclkOut == 1'b1, "R9 clock idle in power-down", sclkOut, 1);
    regWrite(2'd0, 8'h00);
    regRead(2'd0, v);
    check(v == mkCtrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2), "R9 control write ignored",
          v, mkCtrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2));
    regWrite(2'd2, 8'h12);
    edges = 0; last = sclkOut;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sclkOut != last) edges++;
      last = sclkOut;
    end
    check(edges == 0, "R9 no clock edges in power-down", edges, 0);
    regRead(2'd1, v); check(v == 8'h00, "R9 no flags in power-down", v, 0);
    powerDown = 1'b0;
    idle(2);
    regRead(2'd1, v); check(v == 8'h00, "R9 halted byte never completes", v, 0);

    // Slave role, directed modes and cut-short byte
    for (int m = 0; m < 8; m++)
      runSlave(m[2], m[1], m[0], 8'hB4 ^ 8'(m), 8'h2D ^ 8'(m << 3), 0);
    runSlave(1'b0, 1'b0, 1'b0, 8'hE1, 8'h47, 3);
    runSlave(1'b1, 1'b1, 1'b1, 8'h6A, 8'hD2, 5);

    // Constrained random
    for (int i = 0; i < 30; i++) begin
      logic [31:0] rv = $urandom;
      runMaster(rv[0], rv[1], rv[2], rv[4:3], rv[5], rv[15:8], rv[23:16],
                rv[31:28] == 4'hF ? 6 : 0);
    end
    for (int i = 0; i < 8; i++) begin
      logic [31:0] rv = $urandom;
      runSlave(rv[0], rv[1], rv[2], rv[15:8], rv[23:16], rv[31] ? int'(rv[27:24] % 15) + 1 : 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule